// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns two already-conditioned quadrature phase signals and an index pulse into a signed-free 32-bit position count. It has two decoding resolutions. The fine resolution counts every edge of both phases. The coarse resolution counts only the edges of phase A and uses the level of phase B to tell the direction. Each resolution can run in one of two modes. In the free mode the counter wraps around its full range. In the bounded mode it wraps between zero and a programmed maximum.

Alongside the count the block keeps a direction flag and issues one-cycle event pulses for four conditions: a wrap, a change of direction, a match against a compare value, and a rising index edge. The index edge can also reinitialise the count. The value it loads depends on the direction flag. Sticky status and interrupt merging belong to the surrounding register block, which holds these pulses.

The count can be preset through a valid/ready load port, and only while the block is disabled. `load_ready` is high exactly when `enable` is low. A transfer happens on a clock edge where both `load_valid` and `load_ready` are high. While the block is enabled the port applies back-pressure by holding `load_ready` low. Offered data is then neither consumed nor applied, and the producer must keep it until ready returns.

Top module: `qenc_position_counter`

## Requirements
- R1: While `rst_n` is low, `count` is 0 and `dir_up` is 1. All event outputs are 0. With `enable` low after reset, `load_ready` is 1.
- R2: The fine modes are `mode` 2'b00 (free) and 2'b10 (bounded). In these modes, with `enable` high, each sample in which exactly one phase changed moves the count by one. Write the phase pair as {A,B}. The cycle 00→10→11→01→00 counts up and the reverse cycle counts down. The new count appears on the same clock edge that samples the change.
- R3: `dir_up` equals the direction of the most recent counted step, where 1 means up. It keeps its value when no step is counted.
- R4: The coarse modes are `mode` 2'b01 (free) and 2'b11 (bounded). In these modes only a change of phase A is counted. A change of B alone leaves both `count` and `dir_up` unchanged. An A change counts up when A and B differ after the change, and counts down otherwise.
- R5: In the free modes (`mode[1]` = 0), counting up from 0xFFFF_FFFF gives 0 and counting down from 0 gives 0xFFFF_FFFF. Each of these wraps pulses `wrap_evt` together with the new count.
- R6: When both phases change in the same sample, nothing is counted and `dir_up` is left unchanged.
- R7: In the bounded modes (`mode[1]` = 1), counting up from `max_value` gives 0 and counting down from 0 gives `max_value`. Each of these wraps pulses `wrap_evt`.
- R8: `dirchg_evt` pulses for one cycle when a counted step goes the opposite way to the previous `dir_up`.
- R9: With `cmp_en` high, `cmp_evt` pulses for one cycle when a step or an index reload makes `count` equal to `cmp_value`.
- R10: With `enable` high, a rising edge of `index_in` pulses `idx_evt`. If `idx_reload_en` is also high, the same edge sets `count` to 0 when `dir_up` was 1 before that sample, and to `max_value` when it was 0. A reload takes precedence over a step counted in the same sample.
- R11: `load_ready` equals the inverse of `enable`. A transfer sets `count` to `load_data` one cycle later. While `enable` is low, phase and index changes do not alter `count`, `dir_up` or any event output. While `enable` is high, `load_valid` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phase_a | input | 1 | Conditioned phase A |
| phase_b | input | 1 | Conditioned phase B |
| index_in | input | 1 | Conditioned index signal |
| enable | input | 1 | Global counting enable |
| mode | input | 2 | bit0: coarse decode, bit1: bounded wrap |
| cmp_en | input | 1 | Compare event enable |
| idx_reload_en | input | 1 | Index reload enable |
| cmp_value | input | 32 | Compare value |
| max_value | input | 32 | Bounded-mode maximum and down-reload value |
| load_valid | input | 1 | Load request valid |
| load_ready | output | 1 | Load port can accept (block disabled) |
| load_data | input | 32 | Preset value |
| count | output | 32 | Position count |
| dir_up | output | 1 | Direction flag, 1 = up |
| wrap_evt | output | 1 | Wrap pulse |
| dirchg_evt | output | 1 | Direction change pulse |
| cmp_evt | output | 1 | Compare match pulse |
| idx_evt | output | 1 | Index rising edge pulse |

## Verification
Every registered result (`count`, `dir_up` and the four event pulses) is due one clock edge after its stimulus. That edge is the one that samples the phase, index or load change. `load_ready` follows `enable` combinationally within the same cycle. The bench applies each stimulus just after a falling edge and lets the next rising edge take it. It then reads the outputs at the following falling edge. At that falling edge it compares every output against a behavioural model that was advanced on the same rising edge. Each directed scenario adds explicit checks at that same point.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  // Mode field bit meanings
  localparam int MODE_COARSE_BIT = 0;
  localparam int MODE_BOUND_BIT  = 1;

  typedef enum logic [1:0] {
    MODE_FINE_FREE    = 2'b00,
    MODE_COARSE_FREE  = 2'b01,
    MODE_FINE_BOUND   = 2'b10,
    MODE_COARSE_BOUND = 2'b11
  } qenc_mode_e;

  // One decoded movement request
  typedef struct packed {
    logic valid;
    logic up;
  } qenc_step_t;
endpackage

// File: rtl/qenc_edge_decode.sv
module qenc_edge_decode
  import qenc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phase_a,
  input  logic       phase_b,
  input  logic       coarse,
  output qenc_step_t step
);
  logic a_q, b_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= phase_a;
      b_q <= phase_b;
    end
  end

  logic a_chg, b_chg;
  assign a_chg = phase_a ^ a_q;
  assign b_chg = phase_b ^ b_q;

  always_comb begin
    step = '0;
    if (a_chg && b_chg) begin
      step = '0;                        // illegal double change
    end else if (a_chg) begin
      step.valid = 1'b1;
      step.up    = phase_a ^ phase_b;
    end else if (b_chg && !coarse) begin
      step.valid = 1'b1;
      step.up    = ~(phase_a ^ phase_b);
    end
  end
endmodule

// File: rtl/qenc_index_detect.sv
module qenc_index_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic index_in,
  output logic rise
);
  logic idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) idx_q <= 1'b0;
    else        idx_q <= index_in;
  end

  assign rise = index_in & ~idx_q;
endmodule

// File: rtl/qenc_count_core.sv
module qenc_count_core
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             bounded,
  input  qenc_step_t       step,
  input  logic             idx_rise,
  input  logic             idx_reload_en,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic [CNT_W-1:0] max_value,
  input  logic             load_fire,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             wrap_evt,
  output logic             dirchg_evt,
  output logic             cmp_evt,
  output logic             idx_evt
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ZERO     = '0;

  logic [CNT_W-1:0] top, inc_val, dec_val, nxt_cnt;
  logic             nxt_dir, nxt_wrap, nxt_dchg, nxt_cmp, nxt_idx, moved;

  assign top     = bounded ? max_value : ALL_ONES;
  assign inc_val = count + 1'b1;
  assign dec_val = count - 1'b1;

  always_comb begin
    nxt_cnt  = count;
    nxt_dir  = dir_up;
    nxt_wrap = 1'b0;
    nxt_dchg = 1'b0;
    nxt_idx  = 1'b0;
    moved    = 1'b0;
    if (!enable) begin
      if (load_fire) nxt_cnt = load_data;
    end else begin
      nxt_idx = idx_rise;
      if (step.valid) begin
        nxt_dir  = step.up;
        nxt_dchg = step.up ^ dir_up;
      end
      if (idx_rise && idx_reload_en) begin
        nxt_cnt = dir_up ? ZERO : max_value;
        moved   = 1'b1;
      end else if (step.valid) begin
        moved = 1'b1;
        if (step.up) begin
          if (count == top) begin
            nxt_cnt  = ZERO;
            nxt_wrap = 1'b1;
          end else begin
            nxt_cnt = inc_val;
          end
        end else begin
          if (count == ZERO) begin
            nxt_cnt  = top;
            nxt_wrap = 1'b1;
          end else begin
            nxt_cnt = dec_val;
          end
        end
      end
    end
    nxt_cmp = cmp_en && moved && (nxt_cnt == cmp_value);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count      <= ZERO;
      dir_up     <= 1'b1;
      wrap_evt   <= 1'b0;
      dirchg_evt <= 1'b0;
      cmp_evt    <= 1'b0;
      idx_evt    <= 1'b0;
    end else begin
      count      <= nxt_cnt;
      dir_up     <= nxt_dir;
      wrap_evt   <= nxt_wrap;
      dirchg_evt <= nxt_dchg;
      cmp_evt    <= nxt_cmp;
      idx_evt    <= nxt_idx;
    end
  end
endmodule

// File: rtl/qenc_position_counter.sv
module qenc_position_counter
  import qenc_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phase_a,
  input  logic             phase_b,
  input  logic             index_in,
  input  logic             enable,
  input  logic [1:0]       mode,
  input  logic             cmp_en,
  input  logic             idx_reload_en,
  input  logic [CNT_W-1:0] cmp_value,
  input  logic [CNT_W-1:0] max_value,
  input  logic             load_valid,
  output logic             load_ready,
  input  logic [CNT_W-1:0] load_data,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             wrap_evt,
  output logic             dirchg_evt,
  output logic             cmp_evt,
  output logic             idx_evt
);
  qenc_mode_e mode_e;
  qenc_step_t step;
  logic       idx_rise, coarse, bounded, load_fire;

  assign mode_e     = qenc_mode_e'(mode);
  assign coarse     = mode_e[MODE_COARSE_BIT];
  assign bounded    = mode_e[MODE_BOUND_BIT];
  assign load_ready = ~enable;
  assign load_fire  = load_valid & load_ready;

  qenc_edge_decode u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase_a (phase_a),
    .phase_b (phase_b),
    .coarse  (coarse),
    .step    (step)
  );

  qenc_index_detect u_idx (
    .clk      (clk),
    .rst_n    (rst_n),
    .index_in (index_in),
    .rise     (idx_rise)
  );

  qenc_count_core #(.CNT_W(CNT_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .bounded       (bounded),
    .step          (step),
    .idx_rise      (idx_rise),
    .idx_reload_en (idx_reload_en),
    .cmp_en        (cmp_en),
    .cmp_value     (cmp_value),
    .max_value     (max_value),
    .load_fire     (load_fire),
    .load_data     (load_data),
    .count         (count),
    .dir_up        (dir_up),
    .wrap_evt      (wrap_evt),
    .dirchg_evt    (dirchg_evt),
    .cmp_evt       (cmp_evt),
    .idx_evt       (idx_evt)
  );
endmodule

// File: rtl/qenc_position_counter_chk.sv
module qenc_position_counter_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             phase_a,
  input logic             phase_b,
  input logic             index_in,
  input logic             enable,
  input logic             idx_reload_en,
  input logic [CNT_W-1:0] cmp_value,
  input logic [CNT_W-1:0] max_value,
  input logic             load_valid,
  input logic [CNT_W-1:0] load_data,
  input logic [CNT_W-1:0] count,
  input logic             dir_up,
  input logic             wrap_evt,
  input logic             dirchg_evt,
  input logic             cmp_evt,
  input logic             idx_evt
);
  // R11
  disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !load_valid) |=> $stable(count));

  // R11
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && load_valid) |=> (count == $past(load_data)));

  // R5
  wrap_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |-> (count == '0 || count == '1 || count == $past(max_value)));

  // R8
  dirchg_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dirchg_evt |-> (dir_up != $past(dir_up)));

  // R9
  cmp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |-> (count == $past(cmp_value)));

  // R6
  double_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && enable && (phase_a != $past(phase_a)) && (phase_b != $past(phase_b))
     && !(idx_reload_en && index_in && !$past(index_in)))
    |=> ($stable(count) && $stable(dir_up)));

  // R10
  idx_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_evt |-> ($past(enable) && $past(index_in)));
endmodule

bind qenc_position_counter qenc_position_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .phase_a       (phase_a),
  .phase_b       (phase_b),
  .index_in      (index_in),
  .enable        (enable),
  .idx_reload_en (idx_reload_en),
  .cmp_value     (cmp_value),
  .max_value     (max_value),
  .load_valid    (load_valid),
  .load_data     (load_data),
  .count         (count),
  .dir_up        (dir_up),
  .wrap_evt      (wrap_evt),
  .dirchg_evt    (dirchg_evt),
  .cmp_evt       (cmp_evt),
  .idx_evt       (idx_evt)
);

// File: tb/sim_qenc_position_counter.sv
module sim_qenc_position_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_a = 1'b0, phase_b = 1'b0, index_in = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        cmp_en = 1'b0, idx_reload_en = 1'b0;
  logic [31:0] cmp_value = '0, max_value = '0;
  logic        load_valid = 1'b0;
  logic        load_ready;
  logic [31:0] load_data = '0;
  logic [31:0] count;
  logic        dir_up, wrap_evt, dirchg_evt, cmp_evt, idx_evt;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qenc_position_counter u0 (
    .clk(clk), .rst_n(rst_n), .phase_a(phase_a), .phase_b(phase_b), .index_in(index_in),
    .enable(enable), .mode(mode), .cmp_en(cmp_en), .idx_reload_en(idx_reload_en),
    .cmp_value(cmp_value), .max_value(max_value), .load_valid(load_valid),
    .load_ready(load_ready), .load_data(load_data), .count(count), .dir_up(dir_up),
    .wrap_evt(wrap_evt), .dirchg_evt(dirchg_evt), .cmp_evt(cmp_evt), .idx_evt(idx_evt)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  logic [31:0] m_cnt;
  logic        m_dir, m_wrap, m_dchg, m_cmp, m_idx;
  logic        pa, pb, pi;

  function automatic int gray_pos(input logic a, input logic b);
    case ({a, b})
      2'b00: return 0;
      2'b10: return 1;
      2'b11: return 2;
      default: return 3;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 1; m_wrap = 0; m_dchg = 0; m_cmp = 0; m_idx = 0;
      pa = 0; pb = 0; pi = 0;
    end else begin
      int mv;
      logic [31:0] lim;
      logic old_dir, hit;
      m_wrap = 0; m_dchg = 0; m_cmp = 0; m_idx = 0;
      if (!enable) begin
        if (load_valid) m_cnt = load_data;
      end else begin
        mv = 0;
        if (!mode[0]) begin
          int d;
          d = (gray_pos(phase_a, phase_b) - gray_pos(pa, pb) + 4) % 4;
          if (d == 1) mv = 1;
          else if (d == 3) mv = -1;
        end else if (phase_a != pa && phase_b == pb) begin
          mv = ((phase_a && !phase_b) || (!phase_a && phase_b)) ? 1 : -1;
        end
        old_dir = m_dir;
        if (mv != 0) begin
          if ((mv > 0) != m_dir) m_dchg = 1;
          m_dir = (mv > 0);
        end
        lim = mode[1] ? max_value : 32'hFFFF_FFFF;
        hit = 0;
        m_idx = index_in && !pi;
        if (m_idx && idx_reload_en) begin
          m_cnt = old_dir ? 32'd0 : max_value;
          hit = 1;
        end else if (mv == 1) begin
          hit = 1;
          if (m_cnt == lim) begin m_cnt = 0; m_wrap = 1; end
          else m_cnt = m_cnt + 1;
        end else if (mv == -1) begin
          hit = 1;
          if (m_cnt == 0) begin m_cnt = lim; m_wrap = 1; end
          else m_cnt = m_cnt - 1;
        end
        if (hit && cmp_en && m_cnt == cmp_value) m_cmp = 1;
      end
      pa = phase_a; pb = phase_b; pi = index_in;
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2 count",    count,      m_cnt);
      chk("R3 dir",      {31'd0, dir_up},     {31'd0, m_dir});
      chk("R5 wrap",     {31'd0, wrap_evt},   {31'd0, m_wrap});
      chk("R8 dirchg",   {31'd0, dirchg_evt}, {31'd0, m_dchg});
      chk("R9 cmp",      {31'd0, cmp_evt},    {31'd0, m_cmp});
      chk("R10 idx",     {31'd0, idx_evt},    {31'd0, m_idx});
      chk("R11 ready",   {31'd0, load_ready}, {31'd0, ~enable});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic quad(input bit up, input int n);
    for (int i = 0; i < n; i++) begin
      int p;
      p = (gray_pos(phase_a, phase_b) + (up ? 1 : 3)) % 4;
      case (p)
        0: begin phase_a = 0; phase_b = 0; end
        1: begin phase_a = 1; phase_b = 0; end
        2: begin phase_a = 1; phase_b = 1; end
        default: begin phase_a = 0; phase_b = 1; end
      endcase
      tick();
    end
  endtask

  task automatic preset(input logic [31:0] v);
    enable = 0; load_valid = 1; load_data = v;
    tick();
    load_valid = 0;
    enable = 1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1 reset state
    chk("R1 count", count, 32'd0);
    chk("R1 dir", {31'd0, dir_up}, 32'd1);
    chk("R1 events", {28'd0, wrap_evt, dirchg_evt, cmp_evt, idx_evt}, 32'd0);
    rst_n = 1;
    tick();
    chk("R1 ready", {31'd0, load_ready}, 32'd1);

    // R11 load while disabled, phases ignored
    load_valid = 1; load_data = 32'd100; tick(); load_valid = 0;
    chk("R11 load", count, 32'd100);
    quad(1, 2);
    chk("R11 disabled hold", count, 32'd100);
    index_in = 1; tick(); index_in = 0; tick();
    chk("R11 disabled idx", {31'd0, idx_evt}, 32'd0);

    // R2 fine free counting
    enable = 1; mode = 2'b00;
    quad(1, 8);
    chk("R2 up eight", count, 32'd108);
    chk("R3 dir up", {31'd0, dir_up}, 32'd1);
    load_valid = 1; load_data = 32'd5; tick(); load_valid = 0;
    chk("R11 load ignored while enabled", count, 32'd108);
    quad(0, 1);
    chk("R8 reverse pulse", {31'd0, dirchg_evt}, 32'd1);
    chk("R3 dir down", {31'd0, dir_up}, 32'd0);
    quad(0, 2);
    chk("R2 down", count, 32'd105);

    // R6 both phases flip
    phase_a = ~phase_a; phase_b = ~phase_b; tick();
    chk("R6 no count", count, 32'd105);
    chk("R6 dir kept", {31'd0, dir_up}, 32'd0);

    // R4 coarse mode
    mode = 2'b01;
    tick();
    phase_b = ~phase_b; tick();
    chk("R4 B ignored", count, 32'd105);
    phase_a = 0; phase_b = 0; tick();
    phase_a = 1; tick();
    chk("R4 A rise up", count, 32'd106);
    phase_a = 0; tick();
    chk("R4 A fall down", count, 32'd105);

    // R5 free wrap
    mode = 2'b00;
    preset(32'hFFFF_FFFF);
    quad(1, 1);
    chk("R5 up wrap", count, 32'd0);
    chk("R5 up wrap evt", {31'd0, wrap_evt}, 32'd1);
    quad(0, 1);
    chk("R5 down wrap", count, 32'hFFFF_FFFF);

    // R7 bounded wrap
    mode = 2'b10; max_value = 32'd5;
    preset(32'd4);
    quad(1, 1);
    chk("R7 at max", count, 32'd5);
    quad(1, 1);
    chk("R7 up wrap", count, 32'd0);
    chk("R7 up wrap evt", {31'd0, wrap_evt}, 32'd1);
    quad(0, 1);
    chk("R7 down wrap", count, 32'd5);

    // R9 compare
    cmp_en = 1; cmp_value = 32'd3;
    preset(32'd1);
    quad(1, 1);
    chk("R9 no match", {31'd0, cmp_evt}, 32'd0);
    quad(1, 1);
    chk("R9 match", {31'd0, cmp_evt}, 32'd1);
    quad(1, 1);
    chk("R9 past match", count, 32'd4);

    // R10 index reload
    idx_reload_en = 1;
    index_in = 1; tick();
    chk("R10 reload up", count, 32'd0);
    chk("R10 idx evt", {31'd0, idx_evt}, 32'd1);
    index_in = 0;
    quad(0, 2);
    chk("R10 before down reload", count, 32'd4);
    index_in = 1; tick();
    chk("R10 reload down", count, 32'd5);
    index_in = 0; tick();

    tick();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule